// File: doc/BRIEF.md
# Split-View Doorbell Mailbox Channel

This block is one doorbell channel between a sending agent and a receiving agent. Each agent has its own register view, and both views act on one shared 32-bit status word. The sender rings doorbell slots by writing ones into its set register. The receiver gets an interrupt while any message slot is pending, and acknowledges a slot by writing a one to that bit of its clear register. The sender can read the same word back, so it can poll until the receiver has cleared its slot.

Before it rings, the sender can ask the receiving side to wake. It does this by writing a request bit. It then polls a ready bit, which rises a fixed number of cycles later. This delay stands in for a receiver power controller. The block only raises and withdraws the request. The receiver is never driven to sleep from here.

Slots 0 to 30 carry messages. The top status bit is kept for hardware. It records any access made with the secure flag low, and such an access has no other effect.

Top module: `dbell_mbox_chan`

## Requirements
- R1: After reset the shared status word is zero, the receiver interrupt is low, the wake request output is low, and wake ready reads 0.
- R2: A secure write to the sender set register (offset 0xC) ORs the written bits 30:0 into the status word. Bit 31 of the written value is ignored.
- R3: A secure write to the receiver clear register (offset 0x8) clears every status bit written as 1, bit 31 included. Bits written as 0 keep their value.
- R4: A secure read of offset 0x0 in either view returns the whole shared status word.
- R5: The receiver interrupt is high exactly when at least one of status bits 30:0 is 1. Bit 31 alone does not raise it.
- R6: When the same bit is set through the sender view and cleared through the receiver view in the same cycle, the set wins and the bit ends at 1.
- R7: Offset 0xF88, present only in the sender view, holds the wake request in bit 0. A secure write loads bit 0, the register reads back, and the wake request output follows it from the cycle after the write.
- R8: Bit 0 of offset 0xF8C (sender view only) reads 1 from the WAKE_DLY-th clock edge after the wake request register became 1. It reads 0 again on the cycle after the request is withdrawn.
- R9: Any read or write in either view with the secure flag low sets status bit 31. Such a write changes nothing else, and such a read returns zero.
- R10: Offsets not defined for a view read as zero and ignore writes. This includes the clear offset in the sender view, the set offset in the receiver view, and both wake offsets in the receiver view.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| snd_addr_i | input | ADDR_W | Sender view byte address |
| snd_wdata_i | input | 32 | Sender view write data |
| snd_we_i | input | 1 | Sender view write enable |
| snd_re_i | input | 1 | Sender view read enable |
| snd_sec_i | input | 1 | Sender access is secure |
| snd_rdata_o | output | 32 | Sender view read data (combinational) |
| rcv_addr_i | input | ADDR_W | Receiver view byte address |
| rcv_wdata_i | input | 32 | Receiver view write data |
| rcv_we_i | input | 1 | Receiver view write enable |
| rcv_re_i | input | 1 | Receiver view read enable |
| rcv_sec_i | input | 1 | Receiver access is secure |
| rcv_rdata_o | output | 32 | Receiver view read data (combinational) |
| rcv_irq_o | output | 1 | Receiver interrupt, message pending |
| wake_req_o | output | 1 | Wake request toward the receiver power controller |

## Verification
The bench builds the block with ADDR_W at 12, so the wake offsets near the top of the 4 KiB window decode exactly. It sets WAKE_DLY to 3, which is short enough that a poll loop on the ready bit walks every edge of the wake delay and checks both the last edge where ready is low and the first edge where it is high. A simultaneous write through both views shows the set-over-clear priority. Non-secure traffic is aimed at both views and at the wake register, to show that only the reserved bit moves.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int unsigned OFF_STAT = 32'h000;
  localparam int unsigned OFF_CLR  = 32'h008;
  localparam int unsigned OFF_SET  = 32'h00C;
  localparam int unsigned OFF_WREQ = 32'hF88;
  localparam int unsigned OFF_WRDY = 32'hF8C;

  typedef enum logic [2:0] {
    HIT_NONE,
    HIT_STAT,
    HIT_ACT,
    HIT_WREQ,
    HIT_WRDY
  } hit_e;
endpackage

// File: rtl/dbell_view_dec.sv
module dbell_view_dec
  import dbell_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter bit          IS_SND = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic              sec_i,
  input  logic [DATA_W-1:0] stat_i,
  input  logic              wreq_i,
  input  logic              wrdy_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              act_we_o,
  output logic              wake_we_o,
  output logic              nonsec_o
);
  // sender acts through set, receiver through clear
  localparam int unsigned ACT_OFF = IS_SND ? OFF_SET : OFF_CLR;

  hit_e hit;

  always_comb begin
    hit = HIT_NONE;
    if (addr_i == ADDR_W'(OFF_STAT))                hit = HIT_STAT;
    else if (addr_i == ADDR_W'(ACT_OFF))            hit = HIT_ACT;
    else if (IS_SND && addr_i == ADDR_W'(OFF_WREQ)) hit = HIT_WREQ;
    else if (IS_SND && addr_i == ADDR_W'(OFF_WRDY)) hit = HIT_WRDY;
  end

  assign act_we_o  = we_i && sec_i && (hit == HIT_ACT);
  assign wake_we_o = we_i && sec_i && (hit == HIT_WREQ);
  assign nonsec_o  = (we_i || re_i) && !sec_i;

  always_comb begin
    rdata_o = '0;
    if (re_i && sec_i) begin
      unique case (hit)
        HIT_STAT: rdata_o = stat_i;
        HIT_WREQ: rdata_o = {{(DATA_W-1){1'b0}}, wreq_i};
        HIT_WRDY: rdata_o = {{(DATA_W-1){1'b0}}, wrdy_i};
        default:  rdata_o = '0;
      endcase
    end
  end

  AST_NS_NO_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_i |-> (!act_we_o && !wake_we_o && rdata_o == '0)) else $error("AST_NS_NO_ACTION"); // R9
  AST_UNDEF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit == HIT_NONE) |-> (!act_we_o && !wake_we_o && rdata_o == '0)) else $error("AST_UNDEF_QUIET"); // R10
endmodule

// File: rtl/dbell_status.sv
module dbell_status #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_en_i,
  input  logic [DATA_W-1:0] set_val_i,
  input  logic              clr_en_i,
  input  logic [DATA_W-1:0] clr_val_i,
  input  logic              nonsec_i,
  output logic [DATA_W-1:0] status_o,
  output logic              irq_o
);
  localparam int unsigned         RSV_BIT = DATA_W - 1;
  localparam logic [DATA_W-1:0]   SW_MASK = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] status_q, status_d;

  always_comb begin
    status_d = status_q;
    if (clr_en_i) status_d = status_d & ~clr_val_i;
    if (set_en_i) status_d = status_d | (set_val_i & SW_MASK);
    if (nonsec_i) status_d[RSV_BIT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= status_d;
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q & SW_MASK);

  AST_SET_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> ((status_q & $past(set_val_i & SW_MASK)) == $past(set_val_i & SW_MASK)))
    else $error("AST_SET_LANDS"); // R2
  AST_CLR_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && !set_en_i && !nonsec_i) |=> ((status_q & $past(clr_val_i)) == '0))
    else $error("AST_CLR_LANDS"); // R3
  AST_RSV_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_q[RSV_BIT]) |-> $past(nonsec_i)) else $error("AST_RSV_SOURCE"); // R9
  AST_SET_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_en_i && ((set_val_i & SW_MASK) != '0)) |=> irq_o) else $error("AST_SET_IRQ"); // R5
endmodule

// File: rtl/dbell_wake.sv
module dbell_wake #(
  parameter int unsigned WAKE_DLY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic val_i,
  output logic req_o,
  output logic rdy_o
);
  localparam int unsigned CNT_W = (WAKE_DLY < 2) ? 1 : $clog2(WAKE_DLY + 1);

  logic             req_q, rdy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   req_q <= 1'b0;
    else if (we_i) req_q <= val_i;
  end

  // modelled receiver wake-up: ready after WAKE_DLY edges of held request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!req_q) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!rdy_q) begin
      if (cnt_q == CNT_W'(WAKE_DLY - 1)) rdy_q <= 1'b1;
      else                               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign req_o = req_q;
  assign rdy_o = rdy_q;

  AST_RDY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_q |=> !rdy_q) else $error("AST_RDY_DROP"); // R8
  AST_RDY_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_q) |-> (req_q && $past(req_q))) else $error("AST_RDY_RISE"); // R8
  AST_REQ_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (req_q == $past(val_i))) else $error("AST_REQ_WRITE"); // R7
endmodule

// File: rtl/dbell_mbox_chan.sv
module dbell_mbox_chan #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned WAKE_DLY = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] snd_addr_i,
  input  logic [31:0]       snd_wdata_i,
  input  logic              snd_we_i,
  input  logic              snd_re_i,
  input  logic              snd_sec_i,
  output logic [31:0]       snd_rdata_o,
  input  logic [ADDR_W-1:0] rcv_addr_i,
  input  logic [31:0]       rcv_wdata_i,
  input  logic              rcv_we_i,
  input  logic              rcv_re_i,
  input  logic              rcv_sec_i,
  output logic [31:0]       rcv_rdata_o,
  output logic              rcv_irq_o,
  output logic              wake_req_o
);
  localparam int unsigned DATA_W    = 32;
  localparam logic [31:0] WAKE_MASK = 32'h1;

  logic [DATA_W-1:0] status;
  logic snd_act_we, snd_wake_we, snd_nonsec;
  logic rcv_act_we, rcv_wake_we, rcv_nonsec;
  logic wreq, wrdy, wake_we, wake_val;

  dbell_view_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IS_SND(1'b1)) i_snd_dec (
    .clk_i, .rst_ni,
    .addr_i(snd_addr_i), .we_i(snd_we_i), .re_i(snd_re_i), .sec_i(snd_sec_i),
    .stat_i(status), .wreq_i(wreq), .wrdy_i(wrdy),
    .rdata_o(snd_rdata_o), .act_we_o(snd_act_we), .wake_we_o(snd_wake_we),
    .nonsec_o(snd_nonsec)
  );

  dbell_view_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IS_SND(1'b0)) i_rcv_dec (
    .clk_i, .rst_ni,
    .addr_i(rcv_addr_i), .we_i(rcv_we_i), .re_i(rcv_re_i), .sec_i(rcv_sec_i),
    .stat_i(status), .wreq_i(wreq), .wrdy_i(wrdy),
    .rdata_o(rcv_rdata_o), .act_we_o(rcv_act_we), .wake_we_o(rcv_wake_we),
    .nonsec_o(rcv_nonsec)
  );

  dbell_status #(.DATA_W(DATA_W)) i_status (
    .clk_i, .rst_ni,
    .set_en_i(snd_act_we), .set_val_i(snd_wdata_i),
    .clr_en_i(rcv_act_we), .clr_val_i(rcv_wdata_i),
    .nonsec_i(snd_nonsec || rcv_nonsec),
    .status_o(status), .irq_o(rcv_irq_o)
  );

  // receiver decoder never asserts its wake strobe; ORed for a uniform hookup
  assign wake_we  = snd_wake_we || rcv_wake_we;
  assign wake_val = (snd_wdata_i & WAKE_MASK) != '0;

  dbell_wake #(.WAKE_DLY(WAKE_DLY)) i_wake (
    .clk_i, .rst_ni,
    .we_i(wake_we), .val_i(wake_val),
    .req_o(wreq), .rdy_o(wrdy)
  );

  assign wake_req_o = wreq;

  AST_IRQ_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rcv_re_i && rcv_sec_i && rcv_addr_i == '0) |-> (rcv_irq_o == (rcv_rdata_o[30:0] != '0)))
    else $error("AST_IRQ_TRACKS"); // R5
  AST_VIEWS_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snd_re_i && snd_sec_i && snd_addr_i == '0 && rcv_re_i && rcv_sec_i && rcv_addr_i == '0)
    |-> (snd_rdata_o == rcv_rdata_o)) else $error("AST_VIEWS_AGREE"); // R4
endmodule

// File: tb/test_dbell_mbox_chan.sv
module test_dbell_mbox_chan;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned WAKE_DLY = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [ADDR_W-1:0] s_addr = '0, r_addr = '0;
  logic [31:0] s_wdata = '0, r_wdata = '0;
  logic s_we = 1'b0, s_re = 1'b0, s_sec = 1'b1;
  logic r_we = 1'b0, r_re = 1'b0, r_sec = 1'b1;
  logic [31:0] s_rdata, r_rdata;
  logic irq, wreq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dbell_mbox_chan #(.ADDR_W(ADDR_W), .WAKE_DLY(WAKE_DLY)) i_dbell_mbox_chan (
    .clk_i(clk), .rst_ni(rst_ni),
    .snd_addr_i(s_addr), .snd_wdata_i(s_wdata), .snd_we_i(s_we), .snd_re_i(s_re),
    .snd_sec_i(s_sec), .snd_rdata_o(s_rdata),
    .rcv_addr_i(r_addr), .rcv_wdata_i(r_wdata), .rcv_we_i(r_we), .rcv_re_i(r_re),
    .rcv_sec_i(r_sec), .rcv_rdata_o(r_rdata),
    .rcv_irq_o(irq), .wake_req_o(wreq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // view: 1 = sender, 0 = receiver; tasks start and end just after a negedge
  task automatic wr(bit view, int unsigned addr, logic [31:0] data, bit sec);
    if (view) begin s_addr = ADDR_W'(addr); s_wdata = data; s_sec = sec; s_we = 1'b1; end
    else      begin r_addr = ADDR_W'(addr); r_wdata = data; r_sec = sec; r_we = 1'b1; end
    @(posedge clk);
    @(negedge clk);
    s_we = 1'b0; r_we = 1'b0; s_sec = 1'b1; r_sec = 1'b1;
  endtask

  task automatic rd(bit view, int unsigned addr, bit sec, output logic [31:0] data);
    if (view) begin s_addr = ADDR_W'(addr); s_sec = sec; s_re = 1'b1; end
    else      begin r_addr = ADDR_W'(addr); r_sec = sec; r_re = 1'b1; end
    #1;
    data = view ? s_rdata : r_rdata;
    @(negedge clk);
    s_re = 1'b0; r_re = 1'b0; s_sec = 1'b1; r_sec = 1'b1;
  endtask

  task automatic stat_is(string req, logic [31:0] exp);
    logic [31:0] v;
    rd(1'b1, 'h0, 1'b1, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(1'b1, 'h0, 1'b1, v);     chk("R1 snd status", v, 32'h0);
    rd(1'b0, 'h0, 1'b1, v);     chk("R1 rcv status", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 wake_req", {31'b0, wreq}, 32'h0);
    rd(1'b1, 'hF8C, 1'b1, v);   chk("R1 wake ready", v, 32'h0);
  endtask

  task automatic t_set_clear;
    logic [31:0] v;
    wr(1'b1, 'hC, 32'h0000_0005, 1'b1);
    rd(1'b1, 'h0, 1'b1, v);     chk("R4 snd view", v, 32'h5);
    rd(1'b0, 'h0, 1'b1, v);     chk("R4 rcv view", v, 32'h5);
    chk("R5 irq on", {31'b0, irq}, 32'h1);
    wr(1'b1, 'hC, 32'h8000_0010, 1'b1);
    stat_is("R2 or, bit31 ignored", 32'h15);
    wr(1'b0, 'h8, 32'h0000_0001, 1'b1);
    stat_is("R3 partial clear", 32'h14);
    wr(1'b0, 'h8, 32'h0000_0014, 1'b1);
    stat_is("R3 full clear", 32'h0);
    chk("R5 irq off", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_same_cycle;
    s_addr = ADDR_W'('hC); s_wdata = 32'h3; s_we = 1'b1;
    r_addr = ADDR_W'('h8); r_wdata = 32'h1; r_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    s_we = 1'b0; r_we = 1'b0;
    stat_is("R6 set wins", 32'h3);
    wr(1'b0, 'h8, 32'h3, 1'b1);
  endtask

  task automatic t_nonsec;
    logic [31:0] v;
    wr(1'b1, 'hC, 32'h0000_0040, 1'b0);
    stat_is("R9 ns write sets bit31 only", 32'h8000_0000);
    chk("R5 bit31 alone no irq", {31'b0, irq}, 32'h0);
    wr(1'b0, 'h8, 32'h8000_0000, 1'b1);
    stat_is("R3 clear bit31", 32'h0);
    rd(1'b0, 'h0, 1'b0, v);     chk("R9 ns read zero", v, 32'h0);
    stat_is("R9 ns read flags", 32'h8000_0000);
    wr(1'b1, 'hF88, 32'h1, 1'b0);
    chk("R9 ns wake write ignored", {31'b0, wreq}, 32'h0);
    wr(1'b0, 'h8, 32'h8000_0000, 1'b1);
    stat_is("R3 clear bit31 again", 32'h0);
  endtask

  task automatic t_undef;
    logic [31:0] v;
    wr(1'b1, 'hC, 32'h2, 1'b1);
    wr(1'b1, 'h8, 32'hFFFF_FFFF, 1'b1);
    stat_is("R10 snd clear offset ignored", 32'h2);
    wr(1'b0, 'hC, 32'h1, 1'b1);
    stat_is("R10 rcv set offset ignored", 32'h2);
    rd(1'b1, 'h4, 1'b1, v);     chk("R10 undefined reads zero", v, 32'h0);
    wr(1'b0, 'hF88, 32'h1, 1'b1);
    chk("R10 rcv wake write ignored", {31'b0, wreq}, 32'h0);
    wr(1'b0, 'h8, 32'h2, 1'b1);
    stat_is("R10 cleanup", 32'h0);
  endtask

  task automatic t_wake;
    logic [31:0] v;
    wr(1'b1, 'hF88, 32'h1, 1'b1);
    chk("R7 wake_req follows", {31'b0, wreq}, 32'h1);
    // j-th read sees state after edge k+j, k = write edge
    for (int j = 0; j <= WAKE_DLY + 1; j++) begin
      rd(1'b1, 'hF8C, 1'b1, v);
      chk($sformatf("R8 ready edge %0d", j), v, (j >= WAKE_DLY) ? 32'h1 : 32'h0);
    end
    rd(1'b0, 'hF88, 1'b1, v);   chk("R10 rcv wake req reads zero", v, 32'h0);
    rd(1'b0, 'hF8C, 1'b1, v);   chk("R10 rcv wake ready reads zero", v, 32'h0);
    rd(1'b1, 'hF88, 1'b1, v);   chk("R7 req readback", v, 32'h1);
    wr(1'b1, 'hF88, 32'h0, 1'b1);
    chk("R7 wake_req withdrawn", {31'b0, wreq}, 32'h0);
    rd(1'b1, 'hF8C, 1'b1, v);   chk("R8 ready holds one cycle", v, 32'h1);
    rd(1'b1, 'hF8C, 1'b1, v);   chk("R8 ready drops", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_clear();
    t_same_cycle();
    t_nonsec();
    t_undef();
    t_wake();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule